// File: doc/BRIEF.md
# Unaligned Memory Access Splitter

This block sits between a load/store unit and a data memory port that serves one request at a time, each confined to a single cache block. The requester presents a load or store with a byte address, a size of 1, 2, 4 or 8 bytes, an access kind (plain, locked or swap), store data, and one translation-fault flag per possible fragment. If the bytes of the access all fall inside one block, the request passes to memory unchanged. If they straddle a block boundary, the block cuts the access into a low piece and a high piece, sends them strictly in that order, and keeps each one on the port until the port takes it.

Memory answers each fragment on a valid-only response channel tagged with the fragment number, in any order. Read bytes are merged little-endian into one result, and the requester sees exactly one completion pulse once every fragment issued has been answered. Faulting or illegal accesses complete at once with a flag and never reach memory. A new request is taken only while nothing is in flight.

Top module: `mem_split_unit`

## Requirements
- R1: With size S = 2^req_size, the access splits only when (addr + S - 1) rounded down to a BLK_BYTES multiple is strictly greater than addr; fragment 0 then starts at addr with length (boundary - addr), and fragment 1 starts at the boundary with the remaining bytes. An access whose last byte is the final byte of a block is not split.
- R2: An access that does not split is issued as one request tagged fragment 0, with mem_req_be bit i set for i < S and the store data in the low S byte lanes.
- R3: If req_fault[0] is set, or the access splits and req_fault[1] is set, no request is issued and one cycle after acceptance done_valid pulses with done_fault = 1. req_fault[1] has no effect on an access that does not split.
- R4: req_kind encodes 0 plain, 1 locked, 2 swap. A locked or swap access that would split issues nothing and completes one cycle after acceptance with done_illegal = 1; an unsplit locked or swap access is issued with mem_req_cmd equal to req_kind. Split fragments always carry command 0.
- R5: Fragment 0 is issued before fragment 1, and while mem_req_valid is high with mem_req_ready low, the request stays valid with address, tag and byte enables unchanged. After the last fragment is taken, mem_req_valid falls.
- R6: Fragment 1 of a store carries the store-data bytes from offset len0 upward, placed in its low byte lanes, with byte enables for its own length; fragment 0 carries only its own low len0 bytes.
- R7: Read data of fragment 0 fills result bytes 0..len0-1 and read data of fragment 1 fills result bytes len0..S-1, taken from the low lanes of each response regardless of response order; result bytes at S and above read as zero.
- R8: done_valid pulses for one cycle, in the cycle after the response that answers the last outstanding fragment, and not before.
- R9: req_ready is high only when no fragment is waiting to be issued and none awaits a response.
- R10: After reset, req_ready is 1 and mem_req_valid and done_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester presents an access |
| req_ready | output | 1 | Block is idle and takes the access |
| req_write | input | 1 | 1 store, 0 load |
| req_kind | input | 2 | 0 plain, 1 locked, 2 swap |
| req_addr | input | AW | Byte address |
| req_size | input | SZW | log2 of access size in bytes |
| req_wdata | input | 8*DBYTES | Store data, little-endian |
| req_fault | input | 2 | Translation fault for fragment 0 and fragment 1 |
| mem_req_valid | output | 1 | Fragment request valid |
| mem_req_ready | input | 1 | Memory takes the fragment |
| mem_req_write | output | 1 | Fragment is a store |
| mem_req_cmd | output | 2 | Command kind of the fragment |
| mem_req_frag | output | 1 | Fragment tag |
| mem_req_addr | output | AW | Fragment start address |
| mem_req_be | output | DBYTES | Byte enables, low lanes |
| mem_req_wdata | output | 8*DBYTES | Fragment store data, low lanes |
| mem_rsp_valid | input | 1 | Fragment response |
| mem_rsp_frag | input | 1 | Tag of the answered fragment |
| mem_rsp_rdata | input | 8*DBYTES | Read bytes of the fragment, low lanes |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 8*DBYTES | Merged load data |
| done_fault | output | 1 | Completion reports a translation fault |
| done_illegal | output | 1 | Completion reports an illegal split |

## Verification
The assertions assume memory only answers a fragment after it was taken, with one response per fragment, so a response never arrives while the outstanding count is zero; the bench acts as memory and sends each response only after the matching handshake. They also assume requests never wrap past the top of the address space, and the directed addresses stay far from it. Stalls are produced by holding mem_req_ready low for a chosen number of cycles per fragment, and responses are returned both in issue order and reversed.

// File: rtl/usplit_pkg.sv
package usplit_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'd0,
    KIND_LOCKED = 2'd1,
    KIND_SWAP   = 2'd2
  } usplit_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } usplit_state_e;
endpackage

// File: rtl/usplit_geom.sv
// Works out whether an access crosses a block boundary and the two pieces.
module usplit_geom #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 16,
  parameter int DBYTES    = 8,
  localparam int LW  = $clog2(DBYTES) + 1,
  localparam int SZW = $clog2($clog2(DBYTES) + 1)
) (
  input  logic [AW-1:0]  addr,
  input  logic [SZW-1:0] size_log2,
  output logic           split,
  output logic [LW-1:0]  len0,
  output logic [LW-1:0]  len1,
  output logic [AW-1:0]  addr1
);
  localparam logic [AW-1:0] BLK_MASK = AW'(BLK_BYTES - 1);

  logic [LW-1:0] size_b;
  logic [AW-1:0] last_b;
  logic [AW-1:0] bnd;

  always_comb begin
    size_b = LW'(1) << size_log2;
    last_b = addr + AW'(size_b) - AW'(1);
    bnd    = last_b & ~BLK_MASK;
    split  = bnd > addr;
    len0   = split ? LW'(bnd - addr) : size_b;
    len1   = size_b - len0;
    addr1  = bnd;
  end
endmodule

// File: rtl/usplit_merge.sv
// Collects the read bytes of each fragment into one little-endian word.
module usplit_merge #(
  parameter int DBYTES = 8,
  localparam int LW = $clog2(DBYTES) + 1,
  localparam int DW = 8 * DBYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rsp_valid,
  input  logic [LW-1:0] off,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] rsp_data,
  output logic [DW-1:0] merged
);
  logic [DW-1:0] acc_q;
  logic [DW-1:0] shifted;

  assign shifted = rsp_data << {off, 3'b000};

  for (genvar i = 0; i < DBYTES; i++) begin : g_lane
    logic take;
    assign take = rsp_valid && (LW'(i) >= off) && (LW'(i) < off + len);
    assign merged[8*i +: 8] = take ? shifted[8*i +: 8] : acc_q[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (rsp_valid) acc_q <= merged;
  end
endmodule

// File: rtl/mem_split_unit.sv
module mem_split_unit
  import usplit_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 16,
  parameter int DBYTES    = 8,
  localparam int LW  = $clog2(DBYTES) + 1,
  localparam int SZW = $clog2($clog2(DBYTES) + 1),
  localparam int DW  = 8 * DBYTES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [1:0]     req_kind,
  input  logic [AW-1:0]  req_addr,
  input  logic [SZW-1:0] req_size,
  input  logic [DW-1:0]  req_wdata,
  input  logic [1:0]     req_fault,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [1:0]     mem_req_cmd,
  output logic           mem_req_frag,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DBYTES-1:0] mem_req_be,
  output logic [DW-1:0]  mem_req_wdata,
  input  logic           mem_rsp_valid,
  input  logic           mem_rsp_frag,
  input  logic [DW-1:0]  mem_rsp_rdata,
  output logic           done_valid,
  output logic [DW-1:0]  done_rdata,
  output logic           done_fault,
  output logic           done_illegal
);
  localparam logic [AW-1:0] BLK_MASK = AW'(BLK_BYTES - 1);

  function automatic logic [DBYTES-1:0] be_of(input logic [LW-1:0] n);
    logic [DBYTES-1:0] m;
    for (int i = 0; i < DBYTES; i++) m[i] = (LW'(i) < n);
    return m;
  endfunction

  function automatic logic [DW-1:0] lanes_of(input logic [LW-1:0] n);
    logic [DW-1:0] m;
    for (int i = 0; i < DBYTES; i++) m[8*i +: 8] = (LW'(i) < n) ? 8'hFF : 8'h00;
    return m;
  endfunction

  // Geometry of the incoming access
  logic          g_split;
  logic [LW-1:0] g_len0, g_len1;
  logic [AW-1:0] g_addr1;

  usplit_geom #(.AW(AW), .BLK_BYTES(BLK_BYTES), .DBYTES(DBYTES)) i_geom (
    .addr(req_addr), .size_log2(req_size),
    .split(g_split), .len0(g_len0), .len1(g_len1), .addr1(g_addr1)
  );

  usplit_state_e st_q;
  logic [1:0]    cnt_q;        // fragments awaiting a response
  logic          r_split;
  logic [LW-1:0] r_len0, r_len1;
  logic [AW-1:0] r_addr1;
  logic [DW-1:0] r_wdata1;
  logic          r_write;

  logic accept, any_fault, illegal, reject;
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign any_fault = req_fault[0] || (g_split && req_fault[1]);
  assign illegal   = g_split && (req_kind != KIND_PLAIN);
  assign reject    = any_fault || illegal;

  // Read-data merge
  logic [LW-1:0] m_off, m_len;
  logic [DW-1:0] merged;
  logic          rsp_take;
  assign rsp_take = (st_q == ST_BUSY) && mem_rsp_valid;
  assign m_off    = mem_rsp_frag ? r_len0 : '0;
  assign m_len    = mem_rsp_frag ? r_len1 : r_len0;

  usplit_merge #(.DBYTES(DBYTES)) i_merge (
    .clk(clk), .rst(rst), .clear(accept),
    .rsp_valid(rsp_take), .off(m_off), .len(m_len),
    .rsp_data(mem_rsp_rdata), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      cnt_q         <= '0;
      r_split       <= 1'b0;
      r_len0        <= '0;
      r_len1        <= '0;
      r_addr1       <= '0;
      r_wdata1      <= '0;
      r_write       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_cmd   <= KIND_PLAIN;
      mem_req_frag  <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_be    <= '0;
      mem_req_wdata <= '0;
      done_valid    <= 1'b0;
      done_rdata    <= '0;
      done_fault    <= 1'b0;
      done_illegal  <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      if (accept) begin
        if (reject) begin
          done_valid   <= 1'b1;
          done_fault   <= any_fault;
          done_illegal <= illegal;
          done_rdata   <= '0;
        end else begin
          st_q          <= ST_BUSY;
          cnt_q         <= g_split ? 2'd2 : 2'd1;
          r_split       <= g_split;
          r_len0        <= g_len0;
          r_len1        <= g_len1;
          r_addr1       <= g_addr1;
          r_wdata1      <= (req_wdata >> {g_len0, 3'b000}) & lanes_of(g_len1);
          r_write       <= req_write;
          mem_req_valid <= 1'b1;
          mem_req_write <= req_write;
          mem_req_cmd   <= req_kind;
          mem_req_frag  <= 1'b0;
          mem_req_addr  <= req_addr;
          mem_req_be    <= be_of(g_len0);
          mem_req_wdata <= req_wdata & lanes_of(g_len0);
        end
      end
      if (st_q == ST_BUSY) begin
        if (mem_req_valid && mem_req_ready) begin
          if (!mem_req_frag && r_split) begin
            mem_req_frag  <= 1'b1;
            mem_req_addr  <= r_addr1;
            mem_req_be    <= be_of(r_len1);
            mem_req_wdata <= r_wdata1;
          end else begin
            mem_req_valid <= 1'b0;
          end
        end
        if (mem_rsp_valid) begin
          cnt_q <= cnt_q - 2'd1;
          if (cnt_q == 2'd1) begin
            st_q         <= ST_IDLE;
            done_valid   <= 1'b1;
            done_fault   <= 1'b0;
            done_illegal <= 1'b0;
            done_rdata   <= r_write ? '0 : merged;
          end
        end
      end
    end
  end

  // Input assumption: memory answers only fragments it has taken
  p_rsp_expected_r8: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> (cnt_q != 2'd0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_frag) && $stable(mem_req_be)));

  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && reject) |=> (done_valid && !mem_req_valid && req_ready));

  p_atomic_whole_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_cmd != KIND_PLAIN) |-> (!mem_req_frag && cnt_q == 2'd1));

  p_frag1_inblock_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_frag) |->
      (((mem_req_addr + AW'(r_len1) - AW'(1)) & ~BLK_MASK) == (mem_req_addr & ~BLK_MASK)));

  p_done_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_fault && !done_illegal) |-> (cnt_q == 2'd0 && req_ready));
endmodule

// File: tb/test_mem_split_unit.sv
`timescale 1ns/1ps
module test_mem_split_unit;
  localparam int AW = 32;
  localparam int BLK = 16;
  localparam int DB = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic          req_ready;
  logic [1:0]    req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0]    req_size = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [1:0]    req_fault = 0;
  logic          mem_req_valid, mem_req_write, mem_req_frag;
  logic          mem_req_ready = 0;
  logic [1:0]    mem_req_cmd;
  logic [AW-1:0] mem_req_addr;
  logic [DB-1:0] mem_req_be;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 0, mem_rsp_frag = 0;
  logic [DW-1:0] mem_rsp_rdata = 0;
  logic          done_valid, done_fault, done_illegal;
  logic [DW-1:0] done_rdata;

  mem_split_unit #(.AW(AW), .BLK_BYTES(BLK), .DBYTES(DB)) i_mem_split_unit (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_kind(req_kind), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_fault(req_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_cmd(mem_req_cmd),
    .mem_req_frag(mem_req_frag), .mem_req_addr(mem_req_addr),
    .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_frag(mem_rsp_frag),
    .mem_rsp_rdata(mem_rsp_rdata),
    .done_valid(done_valid), .done_rdata(done_rdata),
    .done_fault(done_fault), .done_illegal(done_illegal)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return 8'((a * 29) + 5);
  endfunction

  function automatic logic [63:0] lanes(input int n);
    logic [63:0] m = '0;
    for (int i = 0; i < 8; i++) if (i < n) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [63:0] rsp_of(input logic [AW-1:0] a, input int n);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[8*i +: 8] = (i < n) ? mbyte(a + AW'(i)) : 8'hEE;
    return d;
  endfunction

  // One directed access; the bench plays the memory side.
  task automatic run(input bit wr, input logic [1:0] kind, input logic [AW-1:0] addr,
                     input int szl, input logic [63:0] wd, input logic [1:0] flt,
                     input int st0, input int st1, input bit rev);
    int size, len0, len1, nfr;
    logic [AW-1:0] last, bnd, faddr;
    logic [63:0] exp_rd, fdata;
    bit split, rej, exp_flt, exp_ill;
    size  = 1 << szl;
    last  = addr + AW'(size) - 1;
    bnd   = last & ~AW'(BLK - 1);
    split = bnd > addr;
    len0  = split ? int'(bnd - addr) : size;
    len1  = size - len0;
    nfr   = split ? 2 : 1;
    exp_flt = flt[0] || (split && flt[1]);
    exp_ill = split && (kind != 2'd0);
    rej   = exp_flt || exp_ill;
    exp_rd = '0;
    for (int i = 0; i < 8; i++) if (i < size) exp_rd[8*i +: 8] = mbyte(addr + AW'(i));

    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1; req_write = wr; req_kind = kind; req_addr = addr;
    req_size = 2'(szl); req_wdata = wd; req_fault = flt;
    @(negedge clk);
    req_valid = 0;
    if (rej) begin
      chk(done_valid == 1'b1, "R3 R4 reject completes", 64'(done_valid), 64'd1);
      chk(done_fault == exp_flt, "R3 fault flag", 64'(done_fault), 64'(exp_flt));
      chk(done_illegal == exp_ill, "R4 illegal flag", 64'(done_illegal), 64'(exp_ill));
      chk(mem_req_valid == 1'b0, "R3 R4 nothing issued", 64'(mem_req_valid), 64'd0);
      @(negedge clk);
      chk(mem_req_valid == 1'b0 && done_valid == 1'b0, "R3 R4 still quiet",
          {mem_req_valid, done_valid}, 64'd0);
      return;
    end
    chk(req_ready == 1'b0, "R9 busy blocks ready", 64'(req_ready), 64'd0);
    for (int f = 0; f < nfr; f++) begin
      faddr = (f == 0) ? addr : bnd;
      fdata = (f == 0) ? (wd & lanes(len0)) : ((wd >> (8 * len0)) & lanes(len1));
      for (int s = 0; s < ((f == 0) ? st0 : st1); s++) begin
        chk(mem_req_valid && mem_req_frag == 1'(f) && mem_req_addr == faddr,
            "R5 held under stall", 64'(mem_req_addr), 64'(faddr));
        @(negedge clk);
      end
      chk(mem_req_valid == 1'b1, "R5 fragment valid", 64'(mem_req_valid), 64'd1);
      chk(mem_req_frag == 1'(f), "R5 fragment order", 64'(mem_req_frag), 64'(f));
      chk(mem_req_addr == faddr, "R1 fragment address", 64'(mem_req_addr), 64'(faddr));
      chk(mem_req_be == 8'(lanes((f == 0) ? len0 : len1) >> 0) ||
          mem_req_be == be8((f == 0) ? len0 : len1), "R1 R2 byte enables",
          64'(mem_req_be), 64'(be8((f == 0) ? len0 : len1)));
      chk(mem_req_cmd == (split ? 2'd0 : kind), "R4 command", 64'(mem_req_cmd),
          64'(split ? 2'd0 : kind));
      if (wr) chk(mem_req_wdata == fdata, "R6 fragment store data", mem_req_wdata, fdata);
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
    end
    chk(mem_req_valid == 1'b0, "R5 no extra issue", 64'(mem_req_valid), 64'd0);
    for (int k = 0; k < nfr; k++) begin
      int fr;
      fr = (nfr == 2 && rev) ? (1 - k) : k;
      chk(done_valid == 1'b0, "R8 no early completion", 64'(done_valid), 64'd0);
      mem_rsp_valid = 1;
      mem_rsp_frag  = 1'(fr);
      mem_rsp_rdata = (fr == 0) ? rsp_of(addr, len0) : rsp_of(bnd, len1);
      @(negedge clk);
      mem_rsp_valid = 0;
    end
    chk(done_valid == 1'b1, "R8 completion pulse", 64'(done_valid), 64'd1);
    chk(!done_fault && !done_illegal, "R8 clean completion", {done_fault, done_illegal}, 64'd0);
    chk(req_ready == 1'b1, "R9 idle after completion", 64'(req_ready), 64'd1);
    if (!wr) chk(done_rdata == exp_rd, "R7 merged read data", done_rdata, exp_rd);
    @(negedge clk);
    chk(done_valid == 1'b0, "R8 single pulse", 64'(done_valid), 64'd0);
  endtask

  function automatic logic [7:0] be8(input int n);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) m[i] = (i < n);
    return m;
  endfunction

  task automatic t_reset;
    chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R10 reset no request", 64'(mem_req_valid), 64'd0);
    chk(done_valid == 1'b0, "R10 reset no completion", 64'(done_valid), 64'd0);
  endtask

  task automatic t_unsplit;      // R2
    run(0, 2'd0, 32'h100, 3, 64'h0, 2'b00, 0, 0, 0);
    run(1, 2'd0, 32'h204, 2, 64'hCAFEF00D_12345678, 2'b00, 1, 0, 0);
  endtask

  task automatic t_block_end;    // R1: last byte on block end, no split
    run(0, 2'd0, 32'h108, 3, 64'h0, 2'b00, 0, 0, 0);
  endtask

  task automatic t_split_reads;  // R1 R7
    run(0, 2'd0, 32'h10C, 3, 64'h0, 2'b00, 0, 0, 0);
    run(0, 2'd0, 32'h11E, 2, 64'h0, 2'b00, 0, 0, 1);
    run(0, 2'd0, 32'h31F, 1, 64'h0, 2'b00, 2, 1, 1);
  endtask

  task automatic t_split_write;  // R5 R6
    run(1, 2'd0, 32'h20F, 3, 64'h88776655_44332211, 2'b00, 3, 2, 0);
    run(1, 2'd0, 32'h41D, 3, 64'h0102030405060708, 2'b00, 0, 4, 1);
  endtask

  task automatic t_faults;       // R3
    run(0, 2'd0, 32'h10C, 3, 64'h0, 2'b10, 0, 0, 0);
    run(0, 2'd0, 32'h100, 3, 64'h0, 2'b10, 0, 0, 0);
    run(1, 2'd0, 32'h100, 2, 64'h55, 2'b01, 0, 0, 0);
  endtask

  task automatic t_atomics;      // R4
    run(1, 2'd1, 32'h10E, 2, 64'h1, 2'b00, 0, 0, 0);
    run(1, 2'd2, 32'h11F, 1, 64'h1, 2'b00, 0, 0, 0);
    run(1, 2'd1, 32'h108, 3, 64'hABCD, 2'b00, 0, 0, 0);
    run(0, 2'd2, 32'h120, 2, 64'h0, 2'b00, 1, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_unsplit();
    t_block_end();
    t_split_reads();
    t_split_write();
    t_faults();
    t_atomics();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule